// File: doc/BRIEF.md
# DMA Auto-Alignment Transfer Sizer

This block works out the size of every access in a DMA block transfer when auto-alignment is on. A one-cycle start pulse loads the source and destination addresses, the byte count, a size code for each side and an address-increment enable for each side. The block then emits one access record per clock until the count reaches zero. Each record gives the access size, which side drives the alignment, both addresses and the bytes still left before the access.

The side with the wider programmed size is aligned, and a tie goes to the source. That side's address decides the access size, which is never more than its programmed size and never more than the bytes left. The other side gets a beat size for its first write. A configuration-error flag is computed once when the transfer starts.

Size codes: 00 is 4 bytes, 01 is 1 byte, 10 is 2 bytes and 11 is 16 bytes. Sizes are compared by byte width.

Top module: `aa_sizer`

## Requirements
- R1: After reset, `busy`, `acc_valid`, `done` and `cfg_err` are all 0.
- R2: With `aa_en`=1, `acc_side` is 1 (source) when the source byte width is greater than or equal to the destination byte width, and 2 (destination) otherwise. The widths come from the codes 00=4, 01=1, 10=2, 11=16.
- R3: The address of the aligned side advances by the access size after every access, even when its increment enable is 0. Any other address advances only when its increment enable is 1.
- R4: While more than 16 bytes remain, the access size is the largest of 16, 4, 2 and 1 bytes that divides the aligned address and does not exceed the aligned side's programmed size. Accesses therefore start at smaller sizes and reach the programmed size once the address is aligned to it.
- R5: When 16 or fewer bytes remain, the access size is the largest of 16, 4, 2 and 1 bytes that is no more than the remaining count, divides the aligned address and does not exceed the programmed size. An aligned 16-byte remainder with a 16-byte size therefore gives one 16-byte access.
- R6: Source 0x0001, count 0xF0, source code 00 and destination code 01 give this sequence: a byte at 0x0001, a word at 0x0002, longwords from 0x0004 through 0x00EC, and then a byte at 0x00F0.
- R7: `acc_peer_code` is the largest of 16, 4, 2 and 1 bytes that divides the non-aligned address, does not exceed that side's programmed size and does not exceed the current access size.
- R8: With `aa_en`=1, `cfg_err` is set when the non-aligned address or the byte count is not a multiple of the non-aligned side's programmed size. The aligned side is never checked.
- R9: With `aa_en`=0, `acc_side` is 0. Each access uses the largest source-capped size that fits the remaining count, with no address adaptation, and `cfg_err` checks both sides.
- R10: The first record appears one cycle after the start pulse, and one record follows each cycle while `busy` is 1. `done` pulses together with the last record. A zero count raises `done` one cycle after start and emits no record.
- R11: Each access reduces the remaining count by its size, and the transfer ends with exactly zero bytes left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a transfer (ignored while busy) |
| aa_en | input | 1 | Auto-alignment enable |
| src_addr | input | ADDR_W | Source start address |
| dst_addr | input | ADDR_W | Destination start address |
| byte_count | input | CNT_W | Bytes to move |
| src_code | input | 2 | Source size code |
| dst_code | input | 2 | Destination size code |
| src_inc | input | 1 | Source address increment enable |
| dst_inc | input | 1 | Destination address increment enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| cfg_err | output | 1 | Configuration error of the current transfer |
| acc_valid | output | 1 | Access record valid |
| acc_src | output | ADDR_W | Source address of the access |
| acc_dst | output | ADDR_W | Destination address of the access |
| acc_left | output | CNT_W | Bytes remaining before the access |
| acc_code | output | 2 | Access size code |
| acc_peer_code | output | 2 | First beat size code on the non-aligned side |
| acc_side | output | 2 | 0 none, 1 source aligned, 2 destination aligned |

## Verification
The start pulse is taken at one rising edge. `busy` and `cfg_err` are visible on the falling edge just after that edge. The k-th access record is due on the falling edge after the k-th following rising edge, and `done` arrives in the same sample as the last record. The bench drives inputs and samples outputs only on falling edges. It checks that `acc_valid` is high in every sample from the first record to `done`, and compares each record against a reference model that it steps in lockstep.

// File: rtl/aa_sizer_pkg.sv
package aa_sizer_pkg;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_SRC  = 2'd1,
        SIDE_DST  = 2'd2
    } side_e;

    localparam logic [1:0] CODE_W4  = 2'b00;
    localparam logic [1:0] CODE_W1  = 2'b01;
    localparam logic [1:0] CODE_W2  = 2'b10;
    localparam logic [1:0] CODE_W16 = 2'b11;

    function automatic logic [4:0] code_bytes(input logic [1:0] c);
        case (c)
            CODE_W4:  code_bytes = 5'd4;
            CODE_W1:  code_bytes = 5'd1;
            CODE_W2:  code_bytes = 5'd2;
            default:  code_bytes = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/aa_size_pick.sv
module aa_size_pick
    import aa_sizer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [3:0]       addr_lo,
    input  logic [CNT_W-1:0] left,
    input  logic [1:0]       cap_code,
    output logic [1:0]       code
);
    logic [4:0] cap_b;

    always_comb begin
        cap_b = code_bytes(cap_code);
        code  = CODE_W1;
        if (cap_b >= 5'd2 && left >= CNT_W'(2) && addr_lo[0] == 1'b0)
            code = CODE_W2;
        if (cap_b >= 5'd4 && left >= CNT_W'(4) && addr_lo[1:0] == 2'b00)
            code = CODE_W4;
        if (cap_b >= 5'd16 && left >= CNT_W'(16) && addr_lo == 4'h0)
            code = CODE_W16;
    end
endmodule

// File: rtl/aa_side_select.sv
module aa_side_select
    import aa_sizer_pkg::*;
(
    input  logic       aa_en,
    input  logic [1:0] src_code,
    input  logic [1:0] dst_code,
    output side_e      side
);
    always_comb begin
        if (!aa_en)
            side = SIDE_NONE;
        else if (code_bytes(src_code) >= code_bytes(dst_code))
            side = SIDE_SRC;
        else
            side = SIDE_DST;
    end
endmodule

// File: rtl/aa_cfg_check.sv
module aa_cfg_check
    import aa_sizer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  side_e            side,
    input  logic [3:0]       src_lo,
    input  logic [3:0]       dst_lo,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       src_code,
    input  logic [1:0]       dst_code,
    output logic             err
);
    logic [3:0] src_mask, dst_mask;
    logic       src_bad, dst_bad;

    always_comb begin
        src_mask = 4'(code_bytes(src_code) - 5'd1);
        dst_mask = 4'(code_bytes(dst_code) - 5'd1);
        src_bad  = ((src_lo & src_mask) != 4'h0) || ((count[3:0] & src_mask) != 4'h0);
        dst_bad  = ((dst_lo & dst_mask) != 4'h0) || ((count[3:0] & dst_mask) != 4'h0);
        case (side)
            SIDE_SRC: err = dst_bad;
            SIDE_DST: err = src_bad;
            default:  err = src_bad || dst_bad;
        endcase
    end
endmodule

// File: rtl/aa_sizer.sv
module aa_sizer
    import aa_sizer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              aa_en,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [1:0]        src_code,
    input  logic [1:0]        dst_code,
    input  logic              src_inc,
    input  logic              dst_inc,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_src,
    output logic [ADDR_W-1:0] acc_dst,
    output logic [CNT_W-1:0]  acc_left,
    output logic [1:0]        acc_code,
    output logic [1:0]        acc_peer_code,
    output logic [1:0]        acc_side
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  left;
        logic [1:0]        scode;
        logic [1:0]        dcode;
        logic              sinc;
        logic              dinc;
        side_e             side;
        logic              err;
        logic              done;
        logic              vld;
        logic [ADDR_W-1:0] a_src;
        logic [ADDR_W-1:0] a_dst;
        logic [CNT_W-1:0]  a_left;
        logic [1:0]        a_code;
        logic [1:0]        a_peer;
        side_e             a_side;
    } st_t;

    st_t st_d, st_q;

    side_e      start_side;
    logic       start_err;
    logic [3:0] prim_lo, peer_lo;
    logic [1:0] prim_cap, peer_cap, prim_code, peer_code;
    logic [CNT_W-1:0] prim_bytes;

    aa_side_select u_side (
        .aa_en    (aa_en),
        .src_code (src_code),
        .dst_code (dst_code),
        .side     (start_side)
    );

    aa_cfg_check #(.CNT_W(CNT_W)) u_cfg (
        .side     (start_side),
        .src_lo   (src_addr[3:0]),
        .dst_lo   (dst_addr[3:0]),
        .count    (byte_count),
        .src_code (src_code),
        .dst_code (dst_code),
        .err      (start_err)
    );

    always_comb begin
        case (st_q.side)
            SIDE_SRC: begin
                prim_lo = st_q.src[3:0]; prim_cap = st_q.scode;
                peer_lo = st_q.dst[3:0]; peer_cap = st_q.dcode;
            end
            SIDE_DST: begin
                prim_lo = st_q.dst[3:0]; prim_cap = st_q.dcode;
                peer_lo = st_q.src[3:0]; peer_cap = st_q.scode;
            end
            default: begin
                prim_lo = 4'h0; prim_cap = st_q.scode;
                peer_lo = 4'h0; peer_cap = st_q.dcode;
            end
        endcase
    end

    aa_size_pick #(.CNT_W(CNT_W)) u_prim (
        .addr_lo  (prim_lo),
        .left     (st_q.left),
        .cap_code (prim_cap),
        .code     (prim_code)
    );

    assign prim_bytes = CNT_W'(code_bytes(prim_code));

    aa_size_pick #(.CNT_W(CNT_W)) u_peer (
        .addr_lo  (peer_lo),
        .left     (prim_bytes),
        .cap_code (peer_cap),
        .code     (peer_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.vld  = 1'b0;
        if (st_q.busy) begin
            st_d.vld    = 1'b1;
            st_d.a_src  = st_q.src;
            st_d.a_dst  = st_q.dst;
            st_d.a_left = st_q.left;
            st_d.a_code = prim_code;
            st_d.a_peer = peer_code;
            st_d.a_side = st_q.side;
            if (st_q.sinc || st_q.side == SIDE_SRC)
                st_d.src = st_q.src + ADDR_W'(prim_bytes);
            if (st_q.dinc || st_q.side == SIDE_DST)
                st_d.dst = st_q.dst + ADDR_W'(prim_bytes);
            st_d.left = st_q.left - prim_bytes;
            if (st_q.left == prim_bytes) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start) begin
            st_d.src   = src_addr;
            st_d.dst   = dst_addr;
            st_d.left  = byte_count;
            st_d.scode = src_code;
            st_d.dcode = dst_code;
            st_d.sinc  = src_inc;
            st_d.dinc  = dst_inc;
            st_d.side  = start_side;
            st_d.err   = start_err;
            st_d.busy  = (byte_count != '0);
            st_d.done  = (byte_count == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy          = st_q.busy;
    assign done          = st_q.done;
    assign cfg_err       = st_q.err;
    assign acc_valid     = st_q.vld;
    assign acc_src       = st_q.a_src;
    assign acc_dst       = st_q.a_dst;
    assign acc_left      = st_q.a_left;
    assign acc_code      = st_q.a_code;
    assign acc_peer_code = st_q.a_peer;
    assign acc_side      = st_q.a_side;

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (st_q.left == $past(st_q.left) - CNT_W'(code_bytes(st_q.a_code))));

    // R5
    size_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (CNT_W'(code_bytes(st_q.a_code)) <= st_q.a_left));

    // R4
    src_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.a_side == SIDE_SRC) |->
            ((st_q.a_src % ADDR_W'(code_bytes(st_q.a_code))) == '0));

    // R3
    src_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.a_side == SIDE_SRC) |->
            (st_q.src == st_q.a_src + ADDR_W'(code_bytes(st_q.a_code))));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);

    // R10
    record_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> st_q.vld);
endmodule

// File: tb/aa_sizer_bench.sv
module aa_sizer_bench;
    localparam int CLK_NS = 10;
    localparam int AW = 32;
    localparam int CW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, aa_en = 1'b0, src_inc = 1'b0, dst_inc = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic [1:0] src_code = '0, dst_code = '0;
    logic busy, done, cfg_err, acc_valid;
    logic [AW-1:0] acc_src, acc_dst;
    logic [CW-1:0] acc_left;
    logic [1:0] acc_code, acc_peer_code, acc_side;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    aa_sizer u_aa_sizer (
        .clk(clk), .rst_n(rst_n), .start(start), .aa_en(aa_en),
        .src_addr(src_addr), .dst_addr(dst_addr), .byte_count(byte_count),
        .src_code(src_code), .dst_code(dst_code), .src_inc(src_inc), .dst_inc(dst_inc),
        .busy(busy), .done(done), .cfg_err(cfg_err), .acc_valid(acc_valid),
        .acc_src(acc_src), .acc_dst(acc_dst), .acc_left(acc_left),
        .acc_code(acc_code), .acc_peer_code(acc_peer_code), .acc_side(acc_side)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned width_of(input logic [1:0] c);
        case (c)
            2'b00: return 4;
            2'b01: return 1;
            2'b10: return 2;
            default: return 16;
        endcase
    endfunction

    function automatic logic [1:0] code_of(input int unsigned w);
        case (w)
            16: return 2'b11;
            4:  return 2'b00;
            2:  return 2'b10;
            default: return 2'b01;
        endcase
    endfunction

    // largest of 16/4/2/1 that divides addr and is within cap and left
    function automatic int unsigned best(input int unsigned addr, input int unsigned left,
                                         input int unsigned cap);
        if (cap >= 16 && left >= 16 && addr % 16 == 0) return 16;
        if (cap >= 4 && left >= 4 && addr % 4 == 0) return 4;
        if (cap >= 2 && left >= 2 && addr % 2 == 0) return 2;
        return 1;
    endfunction

    task automatic run_xfer(input bit aa, input int unsigned sa, input int unsigned da,
                            input int unsigned cnt, input logic [1:0] sc, input logic [1:0] dc,
                            input bit si, input bit di, input bit example);
        int unsigned ms = sa, md = da, ml = cnt, sw = width_of(sc), dw = width_of(dc);
        int unsigned side, pa, pc, oa, oc, sz, exp_peer, steps;
        bit exp_err;
        side = !aa ? 0 : (sw >= dw ? 1 : 2);
        if (side == 1)      exp_err = (da % dw != 0) || (cnt % dw != 0);
        else if (side == 2) exp_err = (sa % sw != 0) || (cnt % sw != 0);
        else exp_err = (sa % sw != 0) || (cnt % sw != 0) || (da % dw != 0) || (cnt % dw != 0);
        @(negedge clk);
        aa_en = aa; src_addr = AW'(sa); dst_addr = AW'(da); byte_count = CW'(cnt);
        src_code = sc; dst_code = dc; src_inc = si; dst_inc = di; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (cnt == 0) begin
            // R10 zero count
            check(done == 1'b1 && busy == 1'b0 && acc_valid == 1'b0, "R10 zero count", {busy, done}, 2'b01);
            return;
        end
        check(busy == 1'b1 && acc_valid == 1'b0, "R10 start", {busy, acc_valid}, 2'b10);
        check(cfg_err == exp_err, "R8/R9 cfg_err", cfg_err, exp_err);
        steps = 0;
        forever begin
            @(negedge clk);
            steps++;
            check(acc_valid == 1'b1, "R10 record each cycle", acc_valid, 1);
            if (!acc_valid || steps > 400) return;
            if (side == 2) begin pa = md; pc = dw; oa = ms; oc = sw; end
            else if (side == 1) begin pa = ms; pc = sw; oa = md; oc = dw; end
            else begin pa = 0; pc = sw; oa = 0; oc = dw; end
            sz = best(pa, ml, pc);
            exp_peer = best(oa, sz, oc);
            check(acc_side == 2'(side), "R2 side", acc_side, side);
            check(acc_code == code_of(sz), ml > 16 ? "R4 size" : "R5 size", acc_code, code_of(sz));
            check(acc_peer_code == code_of(exp_peer), "R7 peer", acc_peer_code, code_of(exp_peer));
            check(acc_src == AW'(ms) && acc_dst == AW'(md), "R3 addresses", acc_src, ms);
            check(acc_left == CW'(ml), "R11 left", acc_left, ml);
            if (example) begin
                int unsigned ex;
                ex = (ms == 1 || ms == 'hF0) ? 1 : (ms == 2 ? 2 : 4);
                check(width_of(acc_code) == ex, "R6 example", width_of(acc_code), ex);
            end
            if (si || side == 1) ms += sz;
            if (di || side == 2) md += sz;
            ml -= sz;
            check(done == (ml == 0), "R10 done timing", done, ml == 0);
            if (done || ml == 0) break;
        end
        check(ml == 0, "R11 end count", ml, 0);
        @(negedge clk);
        check(busy == 1'b0 && acc_valid == 1'b0, "R10 idle after", {busy, acc_valid}, 0);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1
        check(busy == 0 && acc_valid == 0 && done == 0 && cfg_err == 0, "R1 reset", {busy, acc_valid, done, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && acc_valid == 0 && done == 0 && cfg_err == 0, "R1 after release", {busy, acc_valid, done, cfg_err}, 0);
        // R6 example: source aligned, byte destination
        run_xfer(1, 'h1, 'h200, 'hF0, 2'b00, 2'b01, 0, 1, 1);
        // R5 exact 16 aligned with 16-byte size
        run_xfer(1, 'h40, 'h80, 16, 2'b11, 2'b11, 1, 1, 0);
        // R5 16 left but misaligned
        run_xfer(1, 'h44, 'h80, 16, 2'b11, 2'b00, 0, 0, 0);
        // R2 destination aligned, R3 source not incremented
        run_xfer(1, 'h3, 'h7, 37, 2'b01, 2'b00, 0, 1, 0);
        // R2 tie goes to source
        run_xfer(1, 'h6, 'h9, 22, 2'b10, 2'b10, 1, 1, 0);
        // R10 zero count
        run_xfer(1, 'h0, 'h0, 0, 2'b00, 2'b00, 1, 1, 0);
        // R9 auto-align off
        run_xfer(0, 'h5, 'h8, 23, 2'b00, 2'b10, 1, 1, 0);
        // R8 clean configuration
        run_xfer(1, 'h1, 'h10, 32, 2'b11, 2'b00, 1, 1, 0);
        for (int i = 0; i < 60; i++) begin
            run_xfer($urandom % 4 != 0, $urandom % 64, $urandom % 64, $urandom % 90,
                     2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 0);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule